// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block is a synchronous controller for a simulated NOR-style flash array kept in a register file. It takes decoded requests: byte program, sector erase, chip erase, erase suspend and erase resume. Each request runs as a timed internal algorithm. A program can only clear bits. An erase first drives its sectors to zero and then to all ones. Nineteen sectors of unequal size are laid out by a boot-variant parameter. A per-sector protect vector blocks program and erase.

While an algorithm runs, reads return a status byte instead of array data. Bit 7 is the complement of the final bit 7 of the target data. Bit 6 flips on every status read. Bit 2 flips only on reads that fall inside a sector being erased. The ready output is low while an algorithm runs.

An erase can be suspended. While it is suspended, reads of other sectors return array data, and bytes outside the erase set can be programmed. A synchronous abort input stops any running algorithm and returns the block to read mode without clearing the array.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After rst_ni is released, ready_o is 1 and every byte reads 8'hFF. A read issued with rd_en_i appears on rd_data_o one clock later.
- R2: req_op_i=1 (program) in read mode holds ready_o low for exactly PROG_CYCLES clocks. After that the byte holds the old value ANDed with req_data_i.
- R3: With BOOT_TOP=0 and UNIT_BYTES=4 the sectors are laid out from address 0 in this order: 0–7, 8–11, 12–15, 16–31, then fifteen sectors of 32 bytes each. BOOT_TOP=1 mirrors this order so the small sectors sit at the top of the address space.
- R4: req_op_i=2 (sector erase) holds ready_o low for PRE_CYCLES+ERS_CYCLES clocks. It leaves every byte of the addressed sector at 8'hFF and every other sector unchanged.
- R5: req_op_i=3 (chip erase) sets every unprotected sector to 8'hFF and leaves protected sectors intact.
- R6: When prot_i bit n is 1, a program or erase aimed at sector n leaves the array unchanged and ready_o stays 1.
- R7: A status byte has bits 5, 4, 3, 1 and 0 at zero. Bit 7 is the inverse of the program data's bit 7 during a program, 0 during an erase, and 1 during a suspend.
- R8: Bit 6 of the status inverts on each consecutive status read while ready_o is 0, and holds during a suspend.
- R9: Bit 2 of the status inverts on a read only when the read address lies in a sector selected for erase. Otherwise it holds.
- R10: req_op_i=4 (suspend) during an erase sets ready_o to 1 on the next clock. While suspended, reads outside the erase set return array data and reads inside it return status.
- R11: While suspended, a program outside the erase set runs and then returns to the suspend state. A program inside the erase set is rejected. req_op_i=5 (resume) continues the erase from where it stopped.
- R12: abort_i=1 sets ready_o to 1 on the next clock. The byte targeted by an aborted program keeps its old value.
- R13: A program or erase request made while ready_o is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; array becomes all ones |
| abort_i | input | 1 | Synchronous abort of any running algorithm |
| req_valid_i | input | 1 | Request strobe, one cycle |
| req_op_i | input | 3 | 1 program, 2 sector erase, 3 chip erase, 4 suspend, 5 resume |
| req_addr_i | input | AW (9) | Byte address of the request |
| req_data_i | input | 8 | Program data |
| prot_i | input | 19 | Per-sector protect bits, bit n for sector n by address order |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | AW (9) | Read byte address |
| rd_data_o | output | 8 | Array data or status byte, one clock after rd_en_i |
| ready_o | output | 1 | High in read mode and while an erase is suspended |

## Verification
Programs are tried twice on the same byte with patterns whose ones only partly overlap. This separates an AND from an overwrite or an OR. Erases target a small sector whose two neighbours were programmed to zero. This shows off-by-one errors in the sector bounds. Status reads alternate between an address inside the erase set and one outside it. This separates the bit 2 toggle from the bit 6 toggle. A suspend with one rejected program and one accepted program, followed by a resume, checks that the erase position and the erase set are kept.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int NSEC   = 19;
  localparam int NUNITS = 128;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_PROG = 3'd1, OP_SERASE = 3'd2,
    OP_CERASE = 3'd3, OP_SUSPEND = 3'd4, OP_RESUME = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_PRE, ST_ERS, ST_SUSP
  } st_e;

  // sector size in units; small sectors at the low end unless mirrored
  function automatic int sec_units(int idx, bit boot_top);
    int k;
    k = boot_top ? (NSEC - 1 - idx) : idx;
    case (k)
      0:       return 2;
      1, 2:    return 1;
      3:       return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int sec_base(int idx, bit boot_top);
    int s;
    s = 0;
    for (int i = 0; i < idx; i++) s += sec_units(i, boot_top);
    return s;
  endfunction

  function automatic int sec_of_byte(int b, int unit, bit boot_top);
    for (int i = 0; i < NSEC; i++) begin
      if (b >= sec_base(i, boot_top) * unit &&
          b < (sec_base(i, boot_top) + sec_units(i, boot_top)) * unit) return i;
    end
    return 0;
  endfunction
endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
  import flash_seq_pkg::*;
#(
  parameter int UNIT_BYTES = 4,
  parameter bit BOOT_TOP   = 1'b0,
  parameter int AW         = 9
) (
  input  logic [AW-1:0]   addr_i,
  output logic [NSEC-1:0] hit_o
);
  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    localparam logic [AW:0] LO = (AW+1)'(sec_base(g, BOOT_TOP) * UNIT_BYTES);
    localparam logic [AW:0] HI = (AW+1)'((sec_base(g, BOOT_TOP) + sec_units(g, BOOT_TOP)) * UNIT_BYTES);
    assign hit_o[g] = ({1'b0, addr_i} >= LO) && ({1'b0, addr_i} < HI);
  end
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_seq_pkg::*;
#(
  parameter int UNIT_BYTES = 4,
  parameter bit BOOT_TOP   = 1'b0,
  parameter int DEPTH      = 512,
  parameter int AW         = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            prog_we_i,
  input  logic [AW-1:0]   prog_addr_i,
  input  logic [7:0]      prog_data_i,
  input  logic            fill_we_i,
  input  logic [7:0]      fill_val_i,
  input  logic [NSEC-1:0] fill_mask_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [7:0]      rd_data_o
);
  logic [DEPTH-1:0][7:0] mem;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    localparam int SEC = sec_of_byte(g, UNIT_BYTES, BOOT_TOP);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        q <= 8'hFF;
      else if (fill_we_i && fill_mask_i[SEC])             q <= fill_val_i;
      else if (prog_we_i && prog_addr_i == AW'(g))        q <= q & prog_data_i;
    end
    assign mem[g] = q;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/flash_status.sv
module flash_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_en_i,
  input  logic       busy_i,
  input  logic       susp_i,
  input  logic       in_mask_i,
  input  logic       dq7_i,
  output logic       stat_sel_o,
  output logic [7:0] stat_o
);
  logic t6_q, t2_q, t6_n, t2_n;

  assign stat_sel_o = busy_i || (susp_i && in_mask_i);
  assign t6_n = t6_q ^ (rd_en_i && busy_i);
  assign t2_n = t2_q ^ (rd_en_i && stat_sel_o && in_mask_i);
  assign stat_o = {dq7_i, t6_n, 3'b000, t2_n, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t6_q <= 1'b0;
      t2_q <= 1'b0;
    end else begin
      t6_q <= t6_n;
      t2_q <= t2_n;
    end
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int UNIT_BYTES  = 4,
  parameter bit BOOT_TOP    = 1'b0,
  parameter int PROG_CYCLES = 8,
  parameter int PRE_CYCLES  = 12,
  parameter int ERS_CYCLES  = 20,
  localparam int DEPTH      = NUNITS * UNIT_BYTES,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            abort_i,
  input  logic            req_valid_i,
  input  logic [2:0]      req_op_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [7:0]      req_data_i,
  input  logic [NSEC-1:0] prot_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [7:0]      rd_data_o,
  output logic            ready_o
);
  localparam int CW = $clog2(PROG_CYCLES + PRE_CYCLES + ERS_CYCLES + 1);

  st_e             st_q, st_d;
  logic [CW-1:0]   pcnt_q, pcnt_d, ecnt_q, ecnt_d;
  logic [NSEC-1:0] emask_q, emask_d, req_hot, rd_hot, erase_sel;
  logic            susp_pre_q, susp_pre_d, in_susp_q, in_susp_d;
  logic [AW-1:0]   paddr_q, paddr_d;
  logic [7:0]      pdata_q, pdata_d;
  logic            prog_we, fill_we;
  logic [7:0]      fill_val, arr_rd, stat, rd_q;
  logic            req_prot, req_in_erase, stat_sel, busy, dq7;
  op_e             op;

  flash_sector_map #(.UNIT_BYTES(UNIT_BYTES), .BOOT_TOP(BOOT_TOP), .AW(AW)) u_req_map (
    .addr_i(req_addr_i), .hit_o(req_hot));
  flash_sector_map #(.UNIT_BYTES(UNIT_BYTES), .BOOT_TOP(BOOT_TOP), .AW(AW)) u_rd_map (
    .addr_i(rd_addr_i), .hit_o(rd_hot));

  assign op           = op_e'(req_op_i);
  assign req_prot     = |(req_hot & prot_i);
  assign req_in_erase = |(req_hot & emask_q);
  assign erase_sel    = ((op == OP_CERASE) ? {NSEC{1'b1}} : req_hot) & ~prot_i;

  always_comb begin
    st_d = st_q; pcnt_d = pcnt_q; ecnt_d = ecnt_q; emask_d = emask_q;
    susp_pre_d = susp_pre_q; in_susp_d = in_susp_q;
    paddr_d = paddr_q; pdata_d = pdata_q;
    prog_we = 1'b0; fill_we = 1'b0; fill_val = 8'hFF;
    case (st_q)
      ST_IDLE: if (req_valid_i) begin
        if (op == OP_PROG && !req_prot) begin
          st_d = ST_PROG; pcnt_d = CW'(PROG_CYCLES - 1);
          paddr_d = req_addr_i; pdata_d = req_data_i; in_susp_d = 1'b0;
        end else if ((op == OP_SERASE || op == OP_CERASE) && |erase_sel) begin
          st_d = ST_PRE; ecnt_d = CW'(PRE_CYCLES - 1); emask_d = erase_sel;
        end
      end
      ST_PROG: begin
        if (pcnt_q == '0) begin
          prog_we = 1'b1;
          st_d = in_susp_q ? ST_SUSP : ST_IDLE;
          in_susp_d = 1'b0;
        end else pcnt_d = pcnt_q - 1'b1;
      end
      ST_PRE, ST_ERS: begin
        if (req_valid_i && op == OP_SUSPEND) begin
          st_d = ST_SUSP; susp_pre_d = (st_q == ST_PRE);
        end else if (ecnt_q == '0) begin
          fill_we = 1'b1;
          if (st_q == ST_PRE) begin
            fill_val = 8'h00; st_d = ST_ERS; ecnt_d = CW'(ERS_CYCLES - 1);
          end else begin
            st_d = ST_IDLE; emask_d = '0;
          end
        end else ecnt_d = ecnt_q - 1'b1;
      end
      ST_SUSP: if (req_valid_i) begin
        if (op == OP_RESUME) st_d = susp_pre_q ? ST_PRE : ST_ERS;
        else if (op == OP_PROG && !req_prot && !req_in_erase) begin
          st_d = ST_PROG; pcnt_d = CW'(PROG_CYCLES - 1);
          paddr_d = req_addr_i; pdata_d = req_data_i; in_susp_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort_i) begin
      st_d = ST_IDLE; emask_d = '0; in_susp_d = 1'b0;
      prog_we = 1'b0; fill_we = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; pcnt_q <= '0; ecnt_q <= '0; emask_q <= '0;
      susp_pre_q <= 1'b0; in_susp_q <= 1'b0; paddr_q <= '0; pdata_q <= '0;
      rd_q <= 8'h00;
    end else begin
      st_q <= st_d; pcnt_q <= pcnt_d; ecnt_q <= ecnt_d; emask_q <= emask_d;
      susp_pre_q <= susp_pre_d; in_susp_q <= in_susp_d;
      paddr_q <= paddr_d; pdata_q <= pdata_d;
      if (rd_en_i) rd_q <= stat_sel ? stat : arr_rd;
    end
  end

  flash_array #(.UNIT_BYTES(UNIT_BYTES), .BOOT_TOP(BOOT_TOP), .DEPTH(DEPTH), .AW(AW)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .prog_we_i(prog_we), .prog_addr_i(paddr_q), .prog_data_i(pdata_q),
    .fill_we_i(fill_we), .fill_val_i(fill_val), .fill_mask_i(emask_q),
    .rd_addr_i(rd_addr_i), .rd_data_o(arr_rd));

  assign busy = (st_q == ST_PROG) || (st_q == ST_PRE) || (st_q == ST_ERS);
  assign dq7  = (st_q == ST_PROG) ? ~pdata_q[7] : (st_q == ST_SUSP);

  flash_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .busy_i(busy),
    .susp_i(st_q == ST_SUSP), .in_mask_i(|(rd_hot & emask_q)), .dq7_i(dq7),
    .stat_sel_o(stat_sel), .stat_o(stat));

  assign rd_data_o = rd_q;
  assign ready_o   = (st_q == ST_IDLE) || (st_q == ST_SUSP);
endmodule

// File: rtl/flash_seq_ctrl_chk.sv
module flash_seq_ctrl_chk
  import flash_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       abort_i,
  input logic       req_valid_i,
  input logic [2:0] req_op_i,
  input logic       rd_en_i,
  input logic [7:0] rd_data_o,
  input logic       ready_o,
  input st_e        st_i,
  input logic       req_prot_i,
  input logic       req_in_erase_i
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;

  p_abort_ready_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> ready_o);

  p_prog_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_i && st_i == ST_IDLE && req_valid_i && req_op_i == 3'd1 && !req_prot_i |=> !ready_o);

  p_prot_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_i && st_i == ST_IDLE && req_valid_i && req_op_i == 3'd1 && req_prot_i |=> ready_o);

  p_susp_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_i && (st_i == ST_PRE || st_i == ST_ERS) && req_valid_i && req_op_i == 3'd4 |=> ready_o);

  p_susp_reject_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !abort_i && st_i == ST_SUSP && req_valid_i && req_op_i == 3'd1 && req_in_erase_i |=> ready_o);

  p_toggle_bit6_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && rd_en_i && !ready_o && $past(rd_en_i && !ready_o) |=> rd_data_o[6] != $past(rd_data_o[6]));

  p_status_zero_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !ready_o |=> rd_data_o[5:3] == 3'b000 && rd_data_o[1:0] == 2'b00);

  p_erase_dq7_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (st_i == ST_PRE || st_i == ST_ERS) |=> !rd_data_o[7]);
endmodule

bind flash_seq_ctrl flash_seq_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .abort_i(abort_i), .req_valid_i(req_valid_i),
  .req_op_i(req_op_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .ready_o(ready_o),
  .st_i(st_q), .req_prot_i(req_prot), .req_in_erase_i(req_in_erase));

// File: tb/flash_seq_ctrl_bench.sv
`timescale 1ns/1ps
module flash_seq_ctrl_bench;
  localparam int DEPTH = 512, AW = 9, NS = 19, PC = 8, PRE = 12, ERS = 20;

  logic clk = 1'b0, rst_n = 1'b0, abort = 1'b0, req_valid = 1'b0, rd_en = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [AW-1:0] req_addr = '0, rd_addr = '0;
  logic [7:0] req_data = 8'h00;
  logic [NS-1:0] prot = '0;
  logic [7:0] rd_data;
  logic ready;

  always #2 clk = ~clk;

  flash_seq_ctrl u_flash_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .req_valid_i(req_valid),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data), .prot_i(prot),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ready_o(ready));

  int nvec = 0, nfail = 0, ncyc = 0;
  bit done = 0;
  string cur = "R1";

  // bottom-boot layout from R3, bytes per sector
  function automatic int b_sec(int a);
    int lo, sz;
    lo = 0;
    for (int i = 0; i < NS; i++) begin
      sz = (i == 0) ? 8 : (i < 3) ? 4 : (i == 3) ? 16 : 32;
      if (a < lo + sz) return i;
      lo += sz;
    end
    return 0;
  endfunction

  // behavioural model: 0 idle, 1 program, 2 preprogram, 3 erase, 4 suspended
  int m_st, m_pc, m_ec;
  logic [7:0] m_mem [DEPTH];
  logic [NS-1:0] m_emask;
  bit m_spre, m_insusp, m_t6, m_t2, m_rdv;
  int m_pa;
  logic [7:0] m_pd, m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_emask = '0; m_t6 = 0; m_t2 = 0; m_rdv = 0; m_insusp = 0;
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
    end else begin
      int rs; bit rp, busy, inm, stat;
      logic [NS-1:0] msk;
      m_rdv = rd_en;
      if (rd_en) begin
        inm = m_emask[b_sec(rd_addr)];
        busy = (m_st >= 1 && m_st <= 3);
        stat = busy || (m_st == 4 && inm);
        if (busy) m_t6 = !m_t6;
        if (stat && inm) m_t2 = !m_t2;
        if (stat) m_rd = {(m_st == 1) ? ~m_pd[7] : (m_st == 4), m_t6, 3'b000, m_t2, 2'b00};
        else      m_rd = m_mem[rd_addr];
      end
      rs = b_sec(req_addr);
      rp = prot[rs];
      if (abort) begin
        m_st = 0; m_emask = '0; m_insusp = 0;
      end else case (m_st)
        0: if (req_valid) begin
          if (req_op == 3'd1 && !rp) begin
            m_st = 1; m_pc = PC; m_pa = req_addr; m_pd = req_data; m_insusp = 0;
          end else if (req_op == 3'd2 || req_op == 3'd3) begin
            msk = ((req_op == 3'd3) ? {NS{1'b1}} : (NS'(1) << rs)) & ~prot;
            if (msk != 0) begin m_emask = msk; m_st = 2; m_ec = PRE; end
          end
        end
        1: begin
          m_pc--;
          if (m_pc == 0) begin
            m_mem[m_pa] = m_mem[m_pa] & m_pd;
            m_st = m_insusp ? 4 : 0; m_insusp = 0;
          end
        end
        2, 3: begin
          if (req_valid && req_op == 3'd4) begin
            m_spre = (m_st == 2); m_st = 4;
          end else begin
            m_ec--;
            if (m_ec == 0) begin
              for (int i = 0; i < DEPTH; i++)
                if (m_emask[b_sec(i)]) m_mem[i] = (m_st == 2) ? 8'h00 : 8'hFF;
              if (m_st == 2) begin m_st = 3; m_ec = ERS; end
              else begin m_st = 0; m_emask = '0; end
            end
          end
        end
        4: if (req_valid) begin
          if (req_op == 3'd5) m_st = m_spre ? 2 : 3;
          else if (req_op == 3'd1 && !rp && !m_emask[rs]) begin
            m_st = 1; m_pc = PC; m_pa = req_addr; m_pd = req_data; m_insusp = 1;
          end
        end
        default: m_st = 0;
      endcase
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  // per-clock comparison with the model
  always @(negedge clk) if (rst_n && !done) begin
    ncyc++;
    nvec++;
    if (ready !== (m_st == 0 || m_st == 4)) begin
      nfail++;
      $display("FAIL %s ready_o act=%b exp=%b", cur, ready, (m_st == 0 || m_st == 4));
    end
    if (m_rdv) begin
      nvec++;
      if (rd_data !== m_rd) begin
        nfail++;
        $display("FAIL %s rd_data_o act=%h exp=%h", cur, rd_data, m_rd);
      end
    end
    if (ncyc > 100000) begin
      done = 1; nfail++;
      $display("FAIL watchdog act=%0d exp=<100000", ncyc);
      summary();
    end
  end

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic req(logic [2:0] op, int a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = AW'(a); req_data = d;
    @(negedge clk);
    req_valid = 0; req_op = 3'd0;
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0; v = rd_data;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, s1, s2;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state and erased array
    cur = "R1";
    chk("R1 ready after reset", {7'd0, ready}, 8'h01);
    rd(0, v);     chk("R1 byte 0", v, 8'hFF);
    rd(511, v);   chk("R1 byte 511", v, 8'hFF);

    // R7 R8 status during program, R2 AND rule and duration
    cur = "R7";
    req(3'd1, 16, 8'h5A);
    rd(16, s1); rd(16, s2);
    chk("R7 dq7 inverse of data", {7'd0, s1[7]}, 8'h01);
    chk("R8 bit6 flips", {7'd0, s1[6] ^ s2[6]}, 8'h01);
    chk("R9 bit2 holds outside erase", {7'd0, s1[2] ^ s2[2]}, 8'h00);
    wait_ready();
    cur = "R2";
    rd(16, v); chk("R2 first program", v, 8'h5A);
    req(3'd1, 16, 8'hC3);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    chk("R2 program busy cycles", 8'(n), 8'(PC));
    rd(16, v); chk("R2 AND of old and new", v, 8'h42);

    // R13 requests while busy
    cur = "R13";
    req(3'd1, 32, 8'h0F);
    req(3'd1, 33, 8'h00);
    req(3'd2, 33, 8'h00);
    wait_ready();
    rd(33, v); chk("R13 program while busy ignored", v, 8'hFF);
    rd(32, v); chk("R13 first program done", v, 8'h0F);

    // R6 protection
    cur = "R6";
    prot = NS'(1) << 6;
    req(3'd1, 100, 8'h00);
    chk("R6 protected program stays ready", {7'd0, ready}, 8'h01);
    rd(100, v); chk("R6 protected byte", v, 8'hFF);
    req(3'd2, 100, 8'h00);
    chk("R6 protected erase stays ready", {7'd0, ready}, 8'h01);

    // R3 R4 R9 sector erase with neighbours
    cur = "R4";
    req(3'd1, 7, 8'h00);  wait_ready();
    req(3'd1, 8, 8'h00);  wait_ready();
    req(3'd1, 11, 8'h00); wait_ready();
    req(3'd1, 12, 8'h00); wait_ready();
    req(3'd2, 9, 8'h00);
    rd(9, s1); rd(9, s2);
    chk("R9 bit2 flips inside erase", {7'd0, s1[2] ^ s2[2]}, 8'h01);
    chk("R7 dq7 low during erase", {7'd0, s1[7]}, 8'h00);
    rd(16, s1); rd(16, s2);
    chk("R9 bit2 holds outside erase", {7'd0, s1[2] ^ s2[2]}, 8'h00);
    wait_ready();
    cur = "R3";
    rd(7, v);  chk("R3 byte below sector kept", v, 8'h00);
    rd(8, v);  chk("R3 sector low byte erased", v, 8'hFF);
    rd(11, v); chk("R3 sector high byte erased", v, 8'hFF);
    rd(12, v); chk("R3 byte above sector kept", v, 8'h00);
    cur = "R4";
    req(3'd2, 13, 8'h00);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    chk("R4 erase busy cycles", 8'(n), 8'(PRE + ERS));
    rd(12, v); chk("R4 erased byte", v, 8'hFF);
    rd(16, v); chk("R4 other sector untouched", v, 8'h42);

    // R10 R11 suspend and resume
    cur = "R10";
    req(3'd2, 32, 8'h00);
    repeat (15) @(negedge clk);
    req(3'd4, 0, 8'h00);
    chk("R10 ready in suspend", {7'd0, ready}, 8'h01);
    rd(16, v); chk("R10 other sector data", v, 8'h42);
    rd(33, s1); rd(33, s2);
    chk("R10 dq7 high in suspend", {7'd0, s1[7]}, 8'h01);
    chk("R10 bit2 flips in suspend", {7'd0, s1[2] ^ s2[2]}, 8'h01);
    chk("R8 bit6 holds in suspend", {7'd0, s1[6] ^ s2[6]}, 8'h00);
    cur = "R11";
    req(3'd1, 34, 8'h00);
    chk("R11 program in erase set rejected", {7'd0, ready}, 8'h01);
    req(3'd1, 80, 8'h33);
    chk("R11 program outside erase set busy", {7'd0, ready}, 8'h00);
    wait_ready();
    rd(80, v); chk("R11 program during suspend", v, 8'h33);
    req(3'd5, 0, 8'h00);
    chk("R11 resume busy", {7'd0, ready}, 8'h00);
    wait_ready();
    rd(32, v); chk("R11 erase completed", v, 8'hFF);
    rd(80, v); chk("R11 suspended program kept", v, 8'h33);

    // R5 chip erase with a protected sector
    cur = "R5";
    prot = '0;
    req(3'd1, 100, 8'h11); wait_ready();
    prot = NS'(1) << 6;
    req(3'd3, 0, 8'h00); wait_ready();
    rd(100, v); chk("R5 protected sector kept", v, 8'h11);
    rd(16, v);  chk("R5 sector erased", v, 8'hFF);
    rd(80, v);  chk("R5 sector erased", v, 8'hFF);

    // R12 abort
    cur = "R12";
    req(3'd1, 64, 8'h00);
    repeat (3) @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    chk("R12 ready after abort", {7'd0, ready}, 8'h01);
    rd(64, v); chk("R12 aborted byte unchanged", v, 8'hFF);

    repeat (2) @(negedge clk);
    done = 1;
    summary();
  end
endmodule